// File: doc/BRIEF.md
# Event Consistency Error Encoder

The block checks that one event is labelled the same way by every party that handles it, and that its payload arrived intact. It compares three event identifiers: the tag the host supplies when it fires a trigger (A), the event number the digitizer writes into its own data (B), and a local count of accepted triggers (C). It also compares the checksum the digitizer computes with the checksum computed locally. The result is a 4-bit error field that goes into an outgoing header.

The trigger counter advances once for every clock cycle in which the trigger input is high. When the evaluate strobe is high, the block compares the current identifiers and checksums. It registers the outcome as `{id_code[2:0], csum_bit}` and holds it until the next strobe. The id code tells whether all three identifiers agree, whether exactly one of them disagrees with the other two (and which one), or whether all three differ. Two flags are derived from the field: one for an identifier disagreement and one for a checksum disagreement. The full counter value is also an output, so it can serve as the local event number.

Top module: `evt_check_enc`

## Requirements
- R1: While reset is asserted, and right after it is released, the error field, both flags and the event counter are all zero.
- R2: The event counter increases by exactly one after each clock cycle in which `trig_i` is high. It wraps from 2^CNT_W-1 to 0.
- R3: If A, B and C are all equal, the field's bits [3:1] are 000.
- R4: If A equals B and C differs, the field's bits [3:1] are 001.
- R5: If A equals C and B differs, the field's bits [3:1] are 010.
- R6: If B equals C and A differs, the field's bits [3:1] are 100.
- R7: If A, B and C all differ from one another, the field's bits [3:1] are 111.
- R8: Field bit [0] is 1 when the two checksums differ and 0 when they are equal.
- R9: Identifiers are compared on their low ID_W bits only. The upper bits of the digitizer number and of the counter have no effect on the field.
- R10: The field takes its new value on the clock edge at which `eval_i` is high. It keeps that value on every edge at which `eval_i` is low, whatever the other inputs do.
- R11: `id_err_o` is high exactly when field bits [3:1] are nonzero. `csum_err_o` always equals field bit [0].
- R12: If a trigger and an evaluate fall in the same cycle, C is the counter value from before that trigger's increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Accepted trigger; the counter advances by one per high cycle |
| host_tag_i | input | ID_W | Event tag from the host (A) |
| dig_num_i | input | NUM_W | Event number reported by the digitizer (B) |
| dig_csum_i | input | CSUM_W | Checksum computed by the digitizer |
| loc_csum_i | input | CSUM_W | Checksum computed locally |
| eval_i | input | 1 | Evaluate strobe; captures the error field |
| err_field_o | output | 4 | Registered {id_code[2:0], checksum mismatch} |
| id_err_o | output | 1 | Identifier disagreement flag |
| csum_err_o | output | 1 | Checksum disagreement flag |
| evt_cnt_o | output | CNT_W | Local trigger count (C in its low ID_W bits) |

## Verification
The bench builds the block with CNT_W set to 9 and the other widths at their defaults (ID_W 8, NUM_W 16, CSUM_W 16). With these values, a few hundred triggers are enough to pass the 256 point. Beyond that point, the counter's low byte matches a tag again while its upper bit does not, and the full 9-bit wrap back to zero is also reached. A digitizer number with nonzero upper bytes shows that only the low byte takes part in the comparison.

// File: rtl/evt_check_enc.sv
module evt_check_enc #(
  parameter int ID_W   = 8,
  parameter int NUM_W  = 16,
  parameter int CNT_W  = 16,
  parameter int CSUM_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic [ID_W-1:0]   host_tag_i,
  input  logic [NUM_W-1:0]  dig_num_i,
  input  logic [CSUM_W-1:0] dig_csum_i,
  input  logic [CSUM_W-1:0] loc_csum_i,
  input  logic              eval_i,
  output logic [3:0]        err_field_o,
  output logic              id_err_o,
  output logic              csum_err_o,
  output logic [CNT_W-1:0]  evt_cnt_o
);

  localparam int W = (NUM_W > CNT_W) ? NUM_W : CNT_W;
  localparam logic [W-1:0] MASK = {{(W-ID_W){1'b0}}, {ID_W{1'b1}}};

  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     a_x, b_x, c_x;
  logic             ab, ac, bc;
  logic [2:0]       code;
  logic [3:0]       field_q;

  assign a_x = W'(host_tag_i);
  assign b_x = W'(dig_num_i);
  assign c_x = W'(cnt_q);

  assign ab = ((a_x ^ b_x) & MASK) == '0;
  assign ac = ((a_x ^ c_x) & MASK) == '0;
  assign bc = ((b_x ^ c_x) & MASK) == '0;

  always_comb begin
    if (ab && ac)  code = 3'b000;
    else if (ab)   code = 3'b001;
    else if (ac)   code = 3'b010;
    else if (bc)   code = 3'b100;
    else           code = 3'b111;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (trig_i) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      field_q <= '0;
    else if (eval_i) field_q <= {code, dig_csum_i != loc_csum_i};
  end

  assign err_field_o = field_q;
  assign id_err_o    = |field_q[3:1];
  assign csum_err_o  = field_q[0];
  assign evt_cnt_o   = cnt_q;

endmodule

// File: rtl/evt_check_enc_chk.sv
module evt_check_enc_chk #(
  parameter int ID_W   = 8,
  parameter int CNT_W  = 16,
  parameter int CSUM_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig_i,
  input logic              eval_i,
  input logic [ID_W-1:0]   a_i,
  input logic [ID_W-1:0]   b_i,
  input logic [ID_W-1:0]   c_i,
  input logic [CSUM_W-1:0] dig_csum_i,
  input logic [CSUM_W-1:0] loc_csum_i,
  input logic [3:0]        err_field_o,
  input logic [CNT_W-1:0]  evt_cnt_o
);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (err_field_o == 4'd0 && evt_cnt_o == '0));

  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> evt_cnt_o == CNT_W'($past(evt_cnt_o) + 1'b1));

  p_cnt_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_i |=> $stable(evt_cnt_o));

  p_all_equal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && a_i == b_i && b_i == c_i) |=> err_field_o[3:1] == 3'b000);

  p_all_differ_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && a_i != b_i && b_i != c_i && a_i != c_i) |=> err_field_o[3:1] == 3'b111);

  p_csum_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eval_i |=> err_field_o[0] == ($past(dig_csum_i) != $past(loc_csum_i)));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_i |=> $stable(err_field_o));

endmodule

bind evt_check_enc evt_check_enc_chk #(
  .ID_W(ID_W), .CNT_W(CNT_W), .CSUM_W(CSUM_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .eval_i(eval_i),
  .a_i(host_tag_i), .b_i(dig_num_i[ID_W-1:0]), .c_i(cnt_q[ID_W-1:0]),
  .dig_csum_i(dig_csum_i), .loc_csum_i(loc_csum_i),
  .err_field_o(err_field_o), .evt_cnt_o(evt_cnt_o)
);

// File: tb/evt_check_enc_tb.sv
module evt_check_enc_tb;
  localparam int CNT_W = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_i = 1'b0;
  logic [7:0]  host_tag_i = '0;
  logic [15:0] dig_num_i = '0;
  logic [15:0] dig_csum_i = '0;
  logic [15:0] loc_csum_i = '0;
  logic        eval_i = 1'b0;
  logic [3:0]  err_field_o;
  logic        id_err_o, csum_err_o;
  logic [CNT_W-1:0] evt_cnt_o;

  int errors = 0;
  int checks = 0;
  int mcnt = 0;
  logic [3:0] last_exp = '0;
  logic [3:0] exp_q[$];
  string      req_q[$];

  always #10 clk = ~clk;

  evt_check_enc #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .host_tag_i(host_tag_i),
    .dig_num_i(dig_num_i), .dig_csum_i(dig_csum_i), .loc_csum_i(loc_csum_i),
    .eval_i(eval_i), .err_field_o(err_field_o), .id_err_o(id_err_o),
    .csum_err_o(csum_err_o), .evt_cnt_o(evt_cnt_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] model(input logic [7:0] a, b, c, input logic [15:0] cd, cl);
    logic [2:0] k;
    if (a == b && b == c)      k = 3'b000;
    else if (a == b)           k = 3'b001;
    else if (a == c)           k = 3'b010;
    else if (b == c)           k = 3'b100;
    else                       k = 3'b111;
    return {k, cd != cl};
  endfunction

  task automatic pulse_trig(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      trig_i = 1'b1;
      mcnt = (mcnt + 1) % (1 << CNT_W);
    end
    @(negedge clk);
    trig_i = 1'b0;
  endtask

  task automatic ev(input logic [7:0] tag, input logic [15:0] num,
                    input logic [15:0] cd, input logic [15:0] cl,
                    input bit t, input string req);
    logic [3:0] e;
    @(negedge clk);
    host_tag_i = tag; dig_num_i = num; dig_csum_i = cd; loc_csum_i = cl;
    eval_i = 1'b1; trig_i = t;
    e = model(tag, num[7:0], 8'(mcnt), cd, cl);
    exp_q.push_back(e);
    req_q.push_back(req);
    last_exp = e;
    if (t) mcnt = (mcnt + 1) % (1 << CNT_W);
    @(negedge clk);
    eval_i = 1'b0; trig_i = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && eval_i) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          check("R10 unexpected result", 32'd1, 32'd0);
        end else begin
          logic [3:0] e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          check(r, 32'(err_field_o), 32'(e));
          check("R11 id flag", 32'(id_err_o), 32'(|e[3:1]));
          check("R11 csum flag", 32'(csum_err_o), 32'(e[0]));
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 field in reset", 32'(err_field_o), 32'd0);
    check("R1 count in reset", 32'(evt_cnt_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 field after reset", 32'(err_field_o), 32'd0);
    check("R1 flags after reset", 32'({id_err_o, csum_err_o}), 32'd0);
    check("R1 count after reset", 32'(evt_cnt_o), 32'd0);

    pulse_trig(5);
    check("R2 count after 5", 32'(evt_cnt_o), 32'd5);

    ev(8'd5, 16'd5, 16'h1234, 16'h1234, 0, "R3 all equal");
    ev(8'd7, 16'd7, 16'h0001, 16'h0001, 0, "R4 A=B!=C");
    ev(8'd5, 16'd9, 16'h0001, 16'h0001, 0, "R5 A=C!=B");
    ev(8'd3, 16'd5, 16'h0001, 16'h0001, 0, "R6 B=C!=A");
    ev(8'd1, 16'd2, 16'h0001, 16'h0001, 0, "R7 all differ");
    ev(8'd5, 16'd5, 16'h00FF, 16'h00FE, 0, "R8 csum differ, ids equal");
    ev(8'd1, 16'd2, 16'hAAAA, 16'h5555, 0, "R8 csum differ, ids differ");
    ev(8'd5, 16'hAB05, 16'h0000, 16'h0000, 0, "R9 upper digitizer bits ignored");

    ev(8'd9, 16'd9, 16'h0000, 16'h0003, 0, "R10 capture before hold");
    @(negedge clk);
    host_tag_i = 8'd0; dig_num_i = 16'd77; dig_csum_i = 16'd1; loc_csum_i = 16'd2;
    repeat (3) @(negedge clk);
    check("R10 held without strobe", 32'(err_field_o), 32'(last_exp));

    ev(8'd5, 16'd5, 16'h0000, 16'h0000, 1, "R12 trig with eval uses old count");
    check("R12 count advanced", 32'(evt_cnt_o), 32'd6);
    ev(8'd6, 16'd6, 16'h0000, 16'h0000, 0, "R12 next eval sees new count");

    pulse_trig(256);
    check("R2 count past 256", 32'(evt_cnt_o), 32'(mcnt));
    ev(8'd6, 16'd6, 16'h0000, 16'h0000, 0, "R9 upper counter bit ignored");
    check("R9 counter high bit set", 32'(evt_cnt_o[8]), 32'd1);

    pulse_trig(512 - mcnt);
    check("R2 counter wrap", 32'(evt_cnt_o), 32'd0);
    ev(8'd0, 16'd0, 16'h0000, 16'h0000, 0, "R3 all equal after wrap");

    repeat (3) @(negedge clk);
    check("R10 queue drained", 32'(exp_q.size()), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule